// File: doc/BRIEF.md
# GPIO Port Input Debouncer

This block cleans up the input pins of one GPIO port before their values reach the input register and the interrupt detector. Each raw pin is first passed through a short synchronizer. Each pin can then be filtered on its own. A filtered pin takes a new level only after that level has stayed unchanged for a programmed number of millisecond ticks. Pins that are not filtered pass their synchronized value straight through.

The whole port shares one stability count, which is a number of milliseconds from 0 to 255. Each pin has its own enable bit and its own timer. Software sets the count with a plain register write. It sets the enable bits through a masked alias, so that each pin can be changed without a read-modify-write. A free-running 1 ms tick comes from outside the block. A build option removes the filtering, and then every pin passes through unfiltered.

Top module: `gpio_port_debounce`

## Requirements
- R1: After reset, `pin_filt_o`, `dbc_count_o` and `dbc_enable_o` are all zero while the raw pins are low.
- R2: A write with `wr_addr` = 0x0F0 loads `wr_data[7:0]` into the shared count, and the new value is visible on `dbc_count_o` after the clock edge. A write to any other offset leaves the count unchanged.
- R3: A write with `wr_addr` = 0x0B0 is a masked enable write. Enable bit i takes `wr_data[i]` only when `wr_data[8+i]` is 1, and every other enable bit holds its value.
- R4: For a pin whose enable bit is 0, `pin_filt_o` follows `pin_raw` with exactly two clock cycles of latency.
- R5: Take an enabled pin with count N whose synchronized input has settled at a level different from its output. Its output holds through the first N ticks and takes the new level on tick N+1.
- R6: With a count of 0, an enabled pin takes a new settled level on the first tick.
- R7: When the synchronized input of an enabled pin returns to the current output level, that pin's timer is cleared. A later departure then needs the full N+1 ticks again.
- R8: Ticks that arrive while an enabled pin's input equals its output do not build up time toward a later change.
- R9: The largest count, 255, holds the output for 255 ticks, and the output changes on tick 256.
- R10: With no tick and no write, the output bits of enabled pins do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | Single-cycle pulse once per millisecond |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write offset within the port |
| wr_data | input | 16 | Write data: mask in [15:8] and value in [7:0] for the enable alias, count in [7:0] |
| pin_raw | input | 8 | Asynchronous raw pin levels |
| pin_filt_o | output | 8 | Filtered pin levels, toward the input register and the interrupt detector |
| dbc_count_o | output | 8 | Current shared count |
| dbc_enable_o | output | 8 | Current per-pin enable bits |

## Verification
The hardest case to set up is a pin whose timer has built up partway, or even fully, and has then been cleared. From the ports that pin looks exactly like one that was never disturbed. To reach it, the stimulus first spends the full tick budget on a new level. It then returns the pin to its old level for a few clocks with no tick, restores the new level, and checks that the output still holds after N ticks and changes only on tick N+1. Ticks that arrive while the input is quiet are covered in a similar way: the bench sends them before a change and then looks for the unchanged N+1 threshold.

// File: rtl/gpio_dbc_pkg.sv
package gpio_dbc_pkg;
   // Which configuration register a write hits
   typedef enum logic [1:0] {
      DBC_TGT_NONE   = 2'd0,
      DBC_TGT_COUNT  = 2'd1,
      DBC_TGT_ENABLE = 2'd2
   } dbc_tgt_e;

   localparam logic [11:0] DBC_COUNT_OFFSET  = 12'h0F0;
   localparam logic [11:0] DBC_ENABLE_OFFSET = 12'h0B0;
endpackage

// File: rtl/gpio_dbc_sync.sv
module gpio_dbc_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("gpio_dbc_sync: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= '0;
            end else if (s == 0) begin
               stage_q[s] <= d_async;
            end else begin
               stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_dbc_cfg.sv
module gpio_dbc_cfg
   import gpio_dbc_pkg::*;
#(
   parameter int          PINS       = 8,
   parameter int          CNT_W      = 8,
   parameter int          ADDR_W     = 12,
   parameter logic [11:0] CNT_OFFSET = DBC_COUNT_OFFSET,
   parameter logic [11:0] ENB_OFFSET = DBC_ENABLE_OFFSET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [2*PINS-1:0] wr_data,
   output logic [CNT_W-1:0]  count_q,
   output logic [PINS-1:0]   enable_q
);
   localparam int WDATA_W = 2 * PINS;

   dbc_tgt_e        tgt;
   logic [PINS-1:0] wmask;
   logic [PINS-1:0] wval;

   generate
      if (CNT_W > WDATA_W) begin : g_bad_cnt
         $error("gpio_dbc_cfg: CNT_W must fit in the write data");
      end
   endgenerate

   assign wmask = wr_data[WDATA_W-1:PINS];
   assign wval  = wr_data[PINS-1:0];

   always_comb begin
      tgt = DBC_TGT_NONE;
      if (wr_en) begin
         if (wr_addr == CNT_OFFSET[ADDR_W-1:0])      tgt = DBC_TGT_COUNT;
         else if (wr_addr == ENB_OFFSET[ADDR_W-1:0]) tgt = DBC_TGT_ENABLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         enable_q <= '0;
      end else begin
         if (tgt == DBC_TGT_COUNT)  count_q  <= wr_data[CNT_W-1:0];
         if (tgt == DBC_TGT_ENABLE) enable_q <= (enable_q & ~wmask) | (wval & wmask);
      end
   end
endmodule

// File: rtl/gpio_dbc_pin_filter.sv
module gpio_dbc_pin_filter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             enable,
   input  logic [CNT_W-1:0] count,
   input  logic             sync_in,
   output logic             filt_q
);
   logic [CNT_W-1:0] timer_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q  <= 1'b0;
         timer_q <= '0;
      end else if (!enable || (sync_in == filt_q)) begin
         // idle, or tracking while disabled: no time is banked
         filt_q  <= sync_in;
         timer_q <= '0;
      end else if (tick) begin
         if (timer_q >= count) begin
            filt_q  <= sync_in;
            timer_q <= '0;
         end else begin
            timer_q <= timer_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/gpio_port_debounce.sv
module gpio_port_debounce
   import gpio_dbc_pkg::*;
#(
   parameter int          PINS        = 8,
   parameter int          CNT_W       = 8,
   parameter int          ADDR_W      = 12,
   parameter int          SYNC_STAGES = 2,
   parameter bit          DEBOUNCE_EN = 1'b1,
   parameter logic [11:0] CNT_OFFSET  = DBC_COUNT_OFFSET,
   parameter logic [11:0] ENB_OFFSET  = DBC_ENABLE_OFFSET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_ms,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [2*PINS-1:0] wr_data,
   input  logic [PINS-1:0]   pin_raw,
   output logic [PINS-1:0]   pin_filt_o,
   output logic [CNT_W-1:0]  dbc_count_o,
   output logic [PINS-1:0]   dbc_enable_o
);
   logic [PINS-1:0]  pin_sync;
   logic [CNT_W-1:0] count_q;
   logic [PINS-1:0]  enable_q;

   generate
      if (PINS < 1 || PINS > 32) begin : g_bad_pins
         $error("gpio_port_debounce: PINS out of range");
      end
      if (ADDR_W > 12 || ADDR_W < 1) begin : g_bad_addr
         $error("gpio_port_debounce: ADDR_W out of range");
      end
   endgenerate

   gpio_dbc_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_raw),
      .q_sync  (pin_sync)
   );

   gpio_dbc_cfg #(
      .PINS(PINS), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
      .CNT_OFFSET(CNT_OFFSET), .ENB_OFFSET(ENB_OFFSET)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .count_q  (count_q),
      .enable_q (enable_q)
   );

   generate
      if (DEBOUNCE_EN) begin : g_filter
         logic [PINS-1:0] filt_q;
         for (genvar p = 0; p < PINS; p++) begin : g_pin
            gpio_dbc_pin_filter #(.CNT_W(CNT_W)) u_pin (
               .clk     (clk),
               .rst_n   (rst_n),
               .tick    (tick_ms),
               .enable  (enable_q[p]),
               .count   (count_q),
               .sync_in (pin_sync[p]),
               .filt_q  (filt_q[p])
            );
            assign pin_filt_o[p] = enable_q[p] ? filt_q[p] : pin_sync[p];
         end
         assign dbc_count_o  = count_q;
         assign dbc_enable_o = enable_q;
      end else begin : g_bypass
         assign pin_filt_o   = pin_sync;
         assign dbc_count_o  = '0;
         assign dbc_enable_o = '0;
      end
   endgenerate
endmodule

// File: rtl/gpio_port_debounce_chk.sv
module gpio_port_debounce_chk #(
   parameter int          PINS       = 8,
   parameter int          CNT_W      = 8,
   parameter int          ADDR_W     = 12,
   parameter logic [11:0] CNT_OFFSET = 12'h0F0,
   parameter logic [11:0] ENB_OFFSET = 12'h0B0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_ms,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [2*PINS-1:0] wr_data,
   input logic [PINS-1:0]   pin_sync,
   input logic [PINS-1:0]   pin_filt_o,
   input logic [CNT_W-1:0]  dbc_count_o,
   input logic [PINS-1:0]   dbc_enable_o
);
   logic wr_cnt, wr_enb;
   assign wr_cnt = wr_en && (wr_addr == CNT_OFFSET[ADDR_W-1:0]);
   assign wr_enb = wr_en && (wr_addr == ENB_OFFSET[ADDR_W-1:0]);

   p_count_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> dbc_count_o == $past(wr_data[CNT_W-1:0]));

   p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> $stable(dbc_count_o));

   p_enable_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_enb |=> ((dbc_enable_o ^ $past(dbc_enable_o)) & ~$past(wr_data[2*PINS-1:PINS])) == '0);

   p_enable_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_enb |=> $stable(dbc_enable_o));

   p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_ms && !wr_en) |=>
         ((pin_filt_o ^ $past(pin_filt_o)) & $past(dbc_enable_o)) == '0);

   p_settled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((pin_filt_o ^ $past(pin_filt_o)) & $past(dbc_enable_o)
                  & ~($past(pin_sync) ^ $past(pin_filt_o))) == '0);

   p_disabled_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_filt_o ^ pin_sync) & ~dbc_enable_o) == '0);
endmodule

bind gpio_port_debounce gpio_port_debounce_chk #(
   .PINS(PINS), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
   .CNT_OFFSET(CNT_OFFSET), .ENB_OFFSET(ENB_OFFSET)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_ms      (tick_ms),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .pin_sync     (pin_sync),
   .pin_filt_o   (pin_filt_o),
   .dbc_count_o  (dbc_count_o),
   .dbc_enable_o (dbc_enable_o)
);

// File: tb/tb_gpio_port_debounce.sv
`timescale 1ns/1ps
module tb_gpio_port_debounce;
   localparam logic [11:0] A_CNT = 12'h0F0;
   localparam logic [11:0] A_ENB = 12'h0B0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_ms = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [7:0]  pin_raw = '0;
   logic [7:0]  pin_filt_o;
   logic [7:0]  dbc_count_o;
   logic [7:0]  dbc_enable_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   gpio_port_debounce dut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pin_raw(pin_raw),
      .pin_filt_o(pin_filt_o), .dbc_count_o(dbc_count_o), .dbc_enable_o(dbc_enable_o)
   );

   // {count, enable, start, new, ticks, expected}
   localparam int NV = 10;
   localparam logic [47:0] VEC [NV] = '{
      {8'd2, 8'hFF, 8'h00, 8'hFF, 8'd2, 8'h00},   // R5 hold at N
      {8'd2, 8'hFF, 8'h00, 8'hFF, 8'd3, 8'hFF},   // R5 change at N+1
      {8'd0, 8'hFF, 8'hFF, 8'h00, 8'd0, 8'hFF},   // R6 no tick yet
      {8'd0, 8'hFF, 8'hFF, 8'h00, 8'd1, 8'h00},   // R6 first tick
      {8'd5, 8'h0F, 8'h00, 8'hFF, 8'd1, 8'hF0},   // R4 mixed enables
      {8'd5, 8'h0F, 8'h00, 8'hFF, 8'd5, 8'hF0},   // R5
      {8'd5, 8'h0F, 8'h00, 8'hFF, 8'd6, 8'hFF},   // R5
      {8'd1, 8'hAA, 8'hA5, 8'h5A, 8'd1, 8'hF0},   // R4 + R5
      {8'd1, 8'hAA, 8'hA5, 8'h5A, 8'd2, 8'h5A},   // R5
      {8'd3, 8'hFF, 8'h3C, 8'hC3, 8'd3, 8'h3C}    // R5
   };

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_ms = 1'b1;
         cyc(1);
         tick_ms = 1'b0;
         cyc(1);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc(1);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // bring every pin's output to lvl with all pins enabled
   task automatic settle(input logic [7:0] lvl);
      wr(A_ENB, 16'hFFFF);
      wr(A_CNT, 16'h0000);
      pin_raw = lvl;
      cyc(4);
      ticks(1);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 output", pin_filt_o, 8'h00);
      chk("R1 count", dbc_count_o, 8'h00);
      chk("R1 enable", dbc_enable_o, 8'h00);

      // R2 count register
      wr(A_CNT, 16'h997B);
      chk("R2 load", dbc_count_o, 8'h7B);
      wr(12'h0F4, 16'h0011);
      chk("R2 other offset", dbc_count_o, 8'h7B);

      // R3 masked enable writes
      wr(A_ENB, 16'hF0FF);
      chk("R3 masked set", dbc_enable_o, 8'hF0);
      wr(A_ENB, 16'h0C04);
      chk("R3 partial", dbc_enable_o, 8'hF4);
      wr(A_ENB, 16'h00FF);
      chk("R3 empty mask", dbc_enable_o, 8'hF4);

      // R4 pass-through latency
      wr(A_ENB, 16'hFF00);
      pin_raw = 8'h69;
      cyc(1);
      chk("R4 one cycle", pin_filt_o, 8'h00);
      cyc(1);
      chk("R4 two cycles", pin_filt_o, 8'h69);

      // table walk (R4 R5 R6)
      for (int v = 0; v < NV; v++) begin
         logic [47:0] e;
         e = VEC[v];
         settle(e[31:24]);
         wr(A_CNT, {8'h00, e[47:40]});
         wr(A_ENB, {8'hFF, e[39:32]});
         pin_raw = e[23:16];
         cyc(4);
         ticks(int'(e[15:8]));
         chk($sformatf("R5 vector %0d", v), pin_filt_o, e[7:0]);
      end

      // R7 return to old level clears the timer
      settle(8'h00);
      wr(A_CNT, 16'h0003);
      pin_raw = 8'hFF;
      cyc(4);
      ticks(3);
      pin_raw = 8'h00;
      cyc(4);
      pin_raw = 8'hFF;
      cyc(4);
      ticks(3);
      chk("R7 restarted hold", pin_filt_o, 8'h00);
      ticks(1);
      chk("R7 change after full span", pin_filt_o, 8'hFF);

      // R8 idle ticks do not bank
      wr(A_CNT, 16'h0002);
      ticks(5);
      pin_raw = 8'h00;
      cyc(4);
      ticks(2);
      chk("R8 idle ticks unbanked", pin_filt_o, 8'hFF);
      ticks(1);
      chk("R8 change", pin_filt_o, 8'h00);

      // R10 no tick, no write
      pin_raw = 8'h81;
      cyc(20);
      chk("R10 held without tick", pin_filt_o, 8'h00);

      // R9 maximum count
      settle(8'h00);
      wr(A_CNT, 16'h00FF);
      pin_raw = 8'h5A;
      cyc(4);
      ticks(255);
      chk("R9 hold at 255", pin_filt_o, 8'h00);
      ticks(1);
      chk("R9 change at 256", pin_filt_o, 8'h5A);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule